// File: doc/BRIEF.md
# Packed Byte Dot-Product and Multiply-Accumulate Unit

This execution unit serves two custom register-register instructions that share one major opcode. One treats each 32-bit source as four signed bytes, multiplies matching bytes, adds up the four products and accumulates the total into the old destination value. The other multiplies the two full 32-bit sources as signed numbers, adds the old destination value and keeps the low word. The pipeline supplies the instruction word together with the rs1, rs2 and old-rd operand values. The unit returns one registered result carrying the destination index and a write enable.

Operands enter through a valid/ready handshake and results leave through another. The unit holds one result register. It takes a new operation when that register is empty or is being drained in the same cycle, so `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result, index and write enable stay frozen and no new operation is accepted. Every accepted instruction produces exactly one output beat. An instruction the unit does not implement, or one that targets register zero, still produces a beat, but that beat has its write enable low.

Top module: `dp_accel_unit`

## Requirements
- R1: When instruction bits [6:0] = 0101011, [31:25] = 0000000 and [14:12] = 001, the result is old_rd plus the sum of four byte products. The byte lanes are bits [7:0], [15:8], [23:16] and [31:24], and lane i of rs1 multiplies lane i of rs2.
- R2: Each byte lane is interpreted as a signed 8-bit value. For example, 0x80 times 0x80 gives +16384 and 0x7F times 0x80 gives -16256.
- R3: In the dot product, the four-product sum is sign-extended and added to the signed old_rd. Only the low 32 bits are returned, so the result wraps and does not saturate.
- R4: When [14:12] = 010 with the same opcode and [31:25] = 0000000, the result is the low 32 bits of rs1*rs2 + old_rd, all treated as signed.
- R5: The destination index is instruction bits [11:7]. When it is zero, the beat carries `out_wen` = 0.
- R6: Any instruction with a different opcode, a funct7 other than 0000000, or a funct3 other than 001 or 010 produces a beat with `out_wen` = 0.
- R7: An operation accepted on a clock edge appears on `out_valid`, `out_data`, `out_rd` and `out_wen` right after that same edge. When no output beat is pending, `out_wen` is 0.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the output fields stay unchanged.
- R9: After reset, `out_valid` = 0, `out_wen` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take the operation |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | 32 | First source value |
| in_rs2 | input | 32 | Second source value |
| in_rd_old | input | 32 | Current destination value |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 32 | Result word |
| out_rd | output | 5 | Destination index |
| out_wen | output | 1 | Result should be written |

## Verification
The dot product is tested with all lanes at the most negative byte, which separates signed from unsigned lane handling. Lanes mixing +127 and -128 catch swapped or misaligned lanes. An accumulator near the positive limit checks that the sum wraps instead of saturating. The multiply-accumulate is driven with -1 times -1 and with the minimum value squared, which tests sign handling of the upper product half and truncation to the low word. Seeded random operands cover both functions more broadly. Directed beats with rd zero, unknown funct3 or funct7, and a foreign opcode check that the write enable stays low, and a stalled consumer checks that the output holds.

// File: rtl/dp_accel_pkg.sv
package dp_accel_pkg;
  localparam logic [6:0] OPC_CUSTOM = 7'b0101011;
  localparam logic [6:0] F7_BASE    = 7'b0000000;
  localparam logic [2:0] F3_DOT     = 3'b001;
  localparam logic [2:0] F3_MAC     = 3'b010;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_DOT  = 2'd1,
    KIND_MAC  = 2'd2
  } op_kind_e;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_accel_pkg::*;
(
  input  logic [31:0] instr,
  output op_kind_e    kind,
  output logic [4:0]  rd,
  output logic        wen
);
  logic unused_src_fields;
  assign unused_src_fields = ^instr[24:15];

  assign rd = instr[11:7];

  always_comb begin
    kind = KIND_NONE;
    if (instr[6:0] == OPC_CUSTOM && instr[31:25] == F7_BASE) begin
      if (instr[14:12] == F3_DOT)      kind = KIND_DOT;
      else if (instr[14:12] == F3_MAC) kind = KIND_MAC;
    end
  end

  assign wen = (kind != KIND_NONE) && (rd != 5'd0);
endmodule

// File: rtl/dp_dot_lanes.sv
module dp_dot_lanes #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] acc,
  output logic [XLEN-1:0] res
);
  localparam int LANES  = XLEN / LANE_W;
  localparam int PROD_W = 2 * LANE_W;
  localparam int SUM_W  = PROD_W + $clog2(LANES) + 1;

  logic [PROD_W-1:0] prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PROD_W-1:0] ea, eb;
    assign ea = {{LANE_W{a[g*LANE_W+LANE_W-1]}}, a[g*LANE_W +: LANE_W]};
    assign eb = {{LANE_W{b[g*LANE_W+LANE_W-1]}}, b[g*LANE_W +: LANE_W]};
    assign prod[g] = ea * eb;
  end

  logic [SUM_W-1:0] sum;
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++)
      sum = sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
  end

  assign res = acc + {{(XLEN-SUM_W){sum[SUM_W-1]}}, sum};
endmodule

// File: rtl/dp_mac.sv
module dp_mac #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] acc,
  output logic [XLEN-1:0] res
);
  localparam int FULL_W = 2 * XLEN;

  logic [FULL_W-1:0] ea, eb, full;
  assign ea   = {{XLEN{a[XLEN-1]}}, a};
  assign eb   = {{XLEN{b[XLEN-1]}}, b};
  assign full = ea * eb;

  logic unused_high_half;
  assign unused_high_half = ^full[FULL_W-1:XLEN];

  assign res = full[XLEN-1:0] + acc;
endmodule

// File: rtl/dp_accel_unit.sv
module dp_accel_unit
  import dp_accel_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_rd_old,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data,
  output logic [4:0]      out_rd,
  output logic            out_wen
);
  op_kind_e        kind;
  logic [4:0]      dec_rd;
  logic            dec_wen;
  logic [XLEN-1:0] dot_res, mac_res, sel_res;

  dp_decode u_dec (
    .instr (in_instr),
    .kind  (kind),
    .rd    (dec_rd),
    .wen   (dec_wen)
  );

  dp_dot_lanes #(.XLEN(XLEN), .LANE_W(LANE_W)) u_dot (
    .a   (in_rs1),
    .b   (in_rs2),
    .acc (in_rd_old),
    .res (dot_res)
  );

  dp_mac #(.XLEN(XLEN)) u_mac (
    .a   (in_rs1),
    .b   (in_rs2),
    .acc (in_rd_old),
    .res (mac_res)
  );

  always_comb begin
    case (kind)
      KIND_DOT: sel_res = dot_res;
      KIND_MAC: sel_res = mac_res;
      default:  sel_res = '0;
    endcase
  end

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
      out_rd    <= '0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_wen   <= dec_wen;
      out_rd    <= dec_rd;
      out_data  <= sel_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
    end
  end
endmodule

// File: rtl/dp_accel_chk.sv
module dp_accel_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_instr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data,
  input logic [4:0]      out_rd,
  input logic            out_wen
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_rd) && $stable(out_wen)); // R8

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_BEAT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R7

  AST_WEN_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_wen); // R7

  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_rd != 5'd0); // R5

  AST_FOREIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_instr[6:0] != 7'b0101011 || in_instr[31:25] != 7'd0) |=> !out_wen); // R6
endmodule

bind dp_accel_unit dp_accel_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_instr  (in_instr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_rd    (out_rd),
  .out_wen   (out_wen)
);

// File: tb/tb_dp_accel_unit.sv
module tb_dp_accel_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_rs1 = '0, in_rs2 = '0, in_rd_old = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [4:0]  out_rd;
  logic        out_wen;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_accel_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd_old(in_rd_old),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_rd(out_rd), .out_wen(out_wen)
  );

  function automatic logic [31:0] mk(logic [6:0] f7, logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] exp_dot(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      int x = int'($signed(a[i*8 +: 8]));
      int y = int'($signed(b[i*8 +: 8]));
      s = s + x * y;
    end
    return c + s;
  endfunction

  function automatic logic [31:0] exp_mac(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    longint p = longint'($signed(a)) * longint'($signed(b)) + longint'($signed(c));
    return p[31:0];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one op, check the beat after the accepting edge
  task automatic issue(logic [31:0] ins, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                       bit exp_wen, logic [31:0] exp_val, string req);
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_rs1 = a; in_rs2 = b; in_rd_old = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " R7 valid"}, {31'd0, out_valid}, 32'd1);
    chk(out_wen === exp_wen, {req, " wen"}, {31'd0, out_wen}, {31'd0, exp_wen});
    chk(out_rd === ins[11:7], {req, " rd"}, {27'd0, out_rd}, {27'd0, ins[11:7]});
    if (exp_wen) chk(out_data === exp_val, {req, " data"}, out_data, exp_val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c, ins;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid === 1'b0, "R9 valid", {31'd0, out_valid}, 32'd0);
    chk(out_wen === 1'b0, "R9 wen", {31'd0, out_wen}, 32'd0);
    chk(in_ready === 1'b1, "R9 ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R1 R2: all lanes -128
    issue(mk(7'd0, 3'b001, 5'd5, 7'b0101011), 32'h80808080, 32'h80808080, 32'd7,
          1'b1, 32'd65543, "R2 neg-neg");
    // R1 R2: mixed +127 and -128 lanes
    issue(mk(7'd0, 3'b001, 5'd6, 7'b0101011), 32'h7F807F01, 32'h80807F02, 32'd0,
          1'b1, exp_dot(32'h7F807F01, 32'h80807F02, 32'd0), "R1 mixed lanes");
    issue(mk(7'd0, 3'b001, 5'd7, 7'b0101011), 32'h00000003, 32'h05000000, 32'd100,
          1'b1, 32'd100, "R1 lane alignment");
    // R3 wrap, no saturation
    issue(mk(7'd0, 3'b001, 5'd8, 7'b0101011), 32'h7F7F7F7F, 32'h7F7F7F7F, 32'h7FFFFFFF,
          1'b1, 32'h7FFFFFFF + 32'd64516, "R3 wrap");
    // R4 MAC
    issue(mk(7'd0, 3'b010, 5'd9, 7'b0101011), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd41,
          1'b1, 32'd42, "R4 neg one");
    issue(mk(7'd0, 3'b010, 5'd10, 7'b0101011), 32'h80000000, 32'h80000000, 32'h12345678,
          1'b1, 32'h12345678, "R4 min squared");
    issue(mk(7'd0, 3'b010, 5'd11, 7'b0101011), 32'h00010003, 32'hFFFF0002, 32'h0,
          1'b1, exp_mac(32'h00010003, 32'hFFFF0002, 32'h0), "R4 truncation");
    // R5 rd zero
    issue(mk(7'd0, 3'b001, 5'd0, 7'b0101011), 32'h01010101, 32'h01010101, 32'd0, 1'b0, 32'd0, "R5 dot rd0");
    issue(mk(7'd0, 3'b010, 5'd0, 7'b0101011), 32'd3, 32'd3, 32'd0, 1'b0, 32'd0, "R5 mac rd0");
    // R6 rejects
    issue(mk(7'd0, 3'b011, 5'd3, 7'b0101011), 32'd3, 32'd3, 32'd0, 1'b0, 32'd0, "R6 funct3");
    issue(mk(7'd0, 3'b000, 5'd3, 7'b0101011), 32'd3, 32'd3, 32'd0, 1'b0, 32'd0, "R6 funct3 zero");
    issue(mk(7'd1, 3'b001, 5'd3, 7'b0101011), 32'd3, 32'd3, 32'd0, 1'b0, 32'd0, "R6 funct7");
    issue(mk(7'd0, 3'b010, 5'd3, 7'b0110011), 32'd3, 32'd3, 32'd0, 1'b0, 32'd0, "R6 opcode");

    // R7: drained beat clears
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 idle valid", {31'd0, out_valid}, 32'd0);
    chk(out_wen === 1'b0, "R7 idle wen", {31'd0, out_wen}, 32'd0);

    // R8 back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_instr = mk(7'd0, 3'b010, 5'd12, 7'b0101011);
    in_rs1 = 32'd6; in_rs2 = 32'd7; in_rd_old = 32'd0;
    @(negedge clk);
    in_instr = mk(7'd0, 3'b001, 5'd13, 7'b0101011);
    in_rs1 = 32'h01010101; in_rs2 = 32'h02020202; in_rd_old = 32'd1;
    chk(in_ready === 1'b0, "R8 ready low", {31'd0, in_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk(out_data === 32'd42, "R8 data held", out_data, 32'd42);
    chk(out_rd === 5'd12, "R8 rd held", {27'd0, out_rd}, 32'd12);
    chk(out_valid === 1'b1, "R8 valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data === 32'd9 && out_rd === 5'd13, "R8 next beat", out_data, 32'd9);

    // R1 R4 random
    void'($urandom(32'd12345));
    for (int k = 0; k < 300; k++) begin
      a = $urandom; b = $urandom; c = $urandom;
      ins = mk(7'd0, (k % 2 == 0) ? 3'b001 : 3'b010, 5'(1 + $urandom % 31), 7'b0101011);
      if (k % 2 == 0) issue(ins, a, b, c, 1'b1, exp_dot(a, b, c), "R1 random dot");
      else            issue(ins, a, b, c, 1'b1, exp_mac(a, b, c), "R4 random mac");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule